// File: doc/BRIEF.md
# SPI Byte-Buffered Data Port

This block is the data path and buffer control of an SPI controller, seen from a byte-addressed register bus. It keeps a receive FIFO and a transmit FIFO of bytes. Software moves data through one data address whose access size (8, 16 or 32 bits) is fixed by a configuration field. A wide write is split into bytes, most significant first. A wide read packs popped bytes back, with the first popped byte in the most significant position. Serial bit timing is not part of this block. On the serial side it trades whole bytes over a plain byte handshake.

In master role, a data write is sent out byte by byte on the master handshake, and every byte that comes back is pushed into the receive FIFO. In slave role, a data write only queues bytes for transmission. Each byte strobed in from the line is pushed into the receive FIFO, and the reply offered to the line is the head of the transmit FIFO. Three level flags compare the FIFO counts against programmable thresholds and drive the receive and transmit interrupt lines. A third interrupt line, for errors, is held low.

Top module: `spi_bufreg`

Register addresses (byte offsets): control 0x00, status 0x03, data 0x04, width config 0x0B, buffer control 0x20, counts 0x22. Bus size codes: 1 = 8 bit, 2 = 16 bit, 3 = 32 bit.

## Requirements
- R1: After reset, both FIFO counts are zero and the status register reads 0xE0. The width config register reads 0x20 (byte width), and all three interrupt lines are low.
- R2: Width config bits 6:5 select the data access size: 1 = byte, 2 = 16 bit, 3 = 32 bit. A data access whose bus size differs from this field is ignored. Such a read returns zero and pops nothing, and such a write is dropped.
- R3: In slave role, a data write queues its bytes into the transmit FIFO, most significant byte first. Serial strobes then reply with them in that order.
- R4: A 16-bit or 32-bit data read pops 2 or 4 bytes, and the first byte popped lands in the most significant position. A read that finds fewer bytes than its width needs (including an empty FIFO) returns zero and changes nothing.
- R5: Status bit 7 is 1 when the receive count is at least buffer-control bits 2:0. Status bit 5 is 1 when the transmit count is at most buffer-control bits 5:4. Status bit 6 is 1 when the transmit count is zero.
- R6: irq[0] equals control bit 7 AND status bit 7, and irq[1] equals control bit 5 AND status bit 5. irq[2] is always low.
- R7: Writing 1 to buffer-control bit 6 empties the receive FIFO, and writing 1 to bit 7 empties the transmit FIFO. Flags and interrupts reflect the empty FIFO from the next cycle. Both bits read as zero, and a flush overrides a same-cycle push.
- R8: The count register holds the receive count in bits 5:0 and the transmit count in bits 11:8.
- R9: With control bit 3 set (master role), a data write sends its bytes most significant first on mst_valid/mst_ready. mst_byte is held while mst_ready is low. Each returned mst_rx_byte is pushed into the receive FIFO. The transmit FIFO is untouched, and a data write that arrives while bytes are still being sent is dropped.
- R10: In slave role, each slv_valid cycle pushes slv_byte into the receive FIFO. slv_reply shows the transmit FIFO head, or zero when that FIFO is empty, and that byte is popped. In master role, slv_valid is ignored and slv_reply is zero.
- R11: A byte pushed into a full FIFO is discarded. The receive FIFO holds 32 bytes and the transmit FIFO holds 8.
- R12: A bus read pop and a serial push to the receive FIFO in the same cycle both take effect, even when the FIFO is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_size | input | 2 | Access size code (1, 2, 3) |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, right-aligned, valid in the access cycle |
| irq | output | 3 | Interrupts: [0] receive, [1] transmit, [2] error |
| mst_valid | output | 1 | Master role: byte to send is valid |
| mst_byte | output | 8 | Master role: byte to send |
| mst_ready | input | 1 | Master role: peer takes the byte this cycle |
| mst_rx_byte | input | 8 | Master role: byte returned for the one taken |
| slv_valid | input | 1 | Slave role: a byte arrived this cycle |
| slv_byte | input | 8 | Slave role: arriving byte |
| slv_reply | output | 8 | Slave role: reply byte for the arriving byte |

## Verification
The receive FIFO can see a bus-read pop and a serial push on the same clock edge. This matters most when the FIFO is already full, because the pop must make room for the push. The bench fills the receive FIFO to its 32-byte limit. It then raises a byte-wide data read and a slave strobe in one cycle. The result is judged three ways: the read returns the oldest byte, the count stays at 32, and the strobed byte appears as the very last one when the FIFO is drained.

// File: rtl/spi_bufreg_pkg.sv
package spi_bufreg_pkg;

   localparam logic [7:0] ADR_CTRL = 8'h00;
   localparam logic [7:0] ADR_STAT = 8'h03;
   localparam logic [7:0] ADR_DATA = 8'h04;
   localparam logic [7:0] ADR_WID  = 8'h0B;
   localparam logic [7:0] ADR_BUFC = 8'h20;
   localparam logic [7:0] ADR_CNT  = 8'h22;

   // bytes moved by one data access of the given width code
   function automatic logic [2:0] wid_bytes(input logic [1:0] w);
      case (w)
         2'd3:    wid_bytes = 3'd4;
         2'd2:    wid_bytes = 3'd2;
         default: wid_bytes = 3'd1;
      endcase
   endfunction

endpackage

// File: rtl/spi_bufreg_fifo.sv
module spi_bufreg_fifo #(
   parameter int DEPTH = 8,
   parameter int PUSHW = 1,
   parameter int POPW  = 1,
   localparam int AW  = $clog2(DEPTH),
   localparam int CW  = $clog2(DEPTH + 1),
   localparam int PNW = $clog2(PUSHW + 1),
   localparam int QNW = $clog2(POPW + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        flush,
   input  logic [PNW-1:0]              push_n,
   input  logic [PUSHW-1:0][7:0]       push_data,
   input  logic [QNW-1:0]              pop_n,
   output logic [POPW-1:0][7:0]        head,
   output logic [CW-1:0]               count
);

   if (DEPTH < 2 || DEPTH != (1 << AW)) begin : g_depth_chk
      $error("spi_bufreg_fifo: DEPTH must be a power of two of at least 2");
   end
   if (PUSHW > DEPTH || POPW > DEPTH) begin : g_lane_chk
      $error("spi_bufreg_fifo: lane counts must not exceed DEPTH");
   end

   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] rd_ptr;
   logic [AW-1:0] wr_ptr;
   int            free_slots;
   int            n_acc;

   // room counts the slots freed by this cycle's pop: the head is read before the edge
   always_comb begin
      free_slots = DEPTH - int'(count) + int'(pop_n);
      n_acc      = (int'(push_n) < free_slots) ? int'(push_n) : free_slots;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         wr_ptr <= wr_ptr + AW'(n_acc);
         rd_ptr <= rd_ptr + AW'(pop_n);
         count  <= count + CW'(n_acc) - CW'(pop_n);
      end
   end

   always_ff @(posedge clk) begin
      if (!flush) begin
         for (int i = 0; i < PUSHW; i++) begin
            if (i < n_acc) mem[wr_ptr + AW'(i)] <= push_data[i];
         end
      end
   end

   for (genvar j = 0; j < POPW; j++) begin : g_head
      assign head[j] = mem[rd_ptr + AW'(j)];
   end

   // R4: the caller never pops more bytes than are stored
   p_pop_le_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pop_n) <= int'(count));

   // R11: occupancy never exceeds the depth
   p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      int'(count) <= DEPTH);

endmodule

// File: rtl/spi_bufreg_mstr.sv
module spi_bufreg_mstr #(
   parameter int NB = 4,
   localparam int NW = $clog2(NB + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [NW-1:0]        load_n,
   input  logic [NB-1:0][7:0]   load_data,
   input  logic                 ready,
   output logic                 valid,
   output logic [7:0]           byte_out
);

   if (NB < 1) begin : g_nb_chk
      $error("spi_bufreg_mstr: NB must be at least 1");
   end

   logic [NB-1:0][7:0] stage;
   logic [NW-1:0]      remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage  <= '0;
         remain <= '0;
      end else if (load && remain == '0) begin
         stage  <= load_data;
         remain <= load_n;
      end else if (remain != '0 && ready) begin
         for (int i = 0; i < NB - 1; i++) stage[i] <= stage[i+1];
         stage[NB-1] <= '0;
         remain      <= remain - NW'(1);
      end
   end

   assign valid    = (remain != '0);
   assign byte_out = stage[0];

   // R9: an offered byte stays put until the peer takes it
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !ready |=> valid && $stable(byte_out));

endmodule

// File: rtl/spi_bufreg.sv
module spi_bufreg
   import spi_bufreg_pkg::*;
#(
   parameter int RX_DEPTH = 32,
   parameter int TX_DEPTH = 8,
   localparam int RXC = $clog2(RX_DEPTH + 1),
   localparam int TXC = $clog2(TX_DEPTH + 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_wr,
   input  logic [7:0]  bus_addr,
   input  logic [1:0]  bus_size,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic [2:0]  irq,
   output logic        mst_valid,
   output logic [7:0]  mst_byte,
   input  logic        mst_ready,
   input  logic [7:0]  mst_rx_byte,
   input  logic        slv_valid,
   input  logic [7:0]  slv_byte,
   output logic [7:0]  slv_reply
);

   if (RXC > 6) begin : g_rx_chk
      $error("spi_bufreg: RX_DEPTH does not fit the 6-bit count field");
   end
   if (TXC > 4) begin : g_tx_chk
      $error("spi_bufreg: TX_DEPTH does not fit the 4-bit count field");
   end

   logic           ctrl_master, ctrl_txie, ctrl_rxie;
   logic [1:0]     cfg_width;
   logic [2:0]     rx_trig;
   logic [1:0]     tx_trig;

   logic           wr_en, rd_en, hit_data, width_ok;
   logic [2:0]     nb;
   logic           rd_ok, wr_data_ok, rx_flush, tx_flush;
   logic           slv_take, mst_fire, mst_load;
   logic [2:0]     rx_pop_n, tx_push_n;
   logic           rx_push_n, tx_pop_n;
   logic [3:0][7:0] wbytes;
   logic [0:0][7:0] rx_push_data;
   logic [3:0][7:0] rx_head;
   logic [0:0][7:0] tx_head;
   logic [RXC-1:0] rx_count;
   logic [TXC-1:0] tx_count;
   logic           rx_lvl, tx_low, tx_end;
   logic [31:0]    rd_mux, cnt_word, data_word;

   assign wr_en      = bus_sel && bus_wr;
   assign rd_en      = bus_sel && !bus_wr;
   assign hit_data   = (bus_addr == ADR_DATA);
   assign width_ok   = (bus_size == cfg_width) && (cfg_width != 2'd0);
   assign nb         = wid_bytes(cfg_width);
   assign rd_ok      = rd_en && hit_data && width_ok && (int'(rx_count) >= int'(nb));
   assign wr_data_ok = wr_en && hit_data && width_ok;
   assign rx_flush   = wr_en && (bus_addr == ADR_BUFC) && bus_wdata[6];
   assign tx_flush   = wr_en && (bus_addr == ADR_BUFC) && bus_wdata[7];

   // split write data into bytes, most significant first
   always_comb begin
      for (int k = 0; k < 4; k++) begin
         if (k < int'(nb)) wbytes[k] = 8'(bus_wdata >> (8 * (int'(nb) - 1 - k)));
         else              wbytes[k] = 8'h00;
      end
   end

   assign slv_take  = slv_valid && !ctrl_master;
   assign mst_fire  = mst_valid && mst_ready;
   assign mst_load  = wr_data_ok && ctrl_master;
   assign tx_push_n = (wr_data_ok && !ctrl_master) ? nb : 3'd0;
   assign tx_pop_n  = slv_take && (tx_count != '0);
   assign rx_pop_n  = rd_ok ? nb : 3'd0;
   assign rx_push_n = slv_take || mst_fire;
   assign rx_push_data[0] = mst_fire ? mst_rx_byte : slv_byte;
   assign slv_reply = (!ctrl_master && tx_count != '0) ? tx_head[0] : 8'h00;

   spi_bufreg_fifo #(.DEPTH(RX_DEPTH), .PUSHW(1), .POPW(4)) i_rx_fifo (
      .clk(clk), .rst_n(rst_n), .flush(rx_flush),
      .push_n(rx_push_n), .push_data(rx_push_data),
      .pop_n(rx_pop_n), .head(rx_head), .count(rx_count)
   );

   spi_bufreg_fifo #(.DEPTH(TX_DEPTH), .PUSHW(4), .POPW(1)) i_tx_fifo (
      .clk(clk), .rst_n(rst_n), .flush(tx_flush),
      .push_n(tx_push_n), .push_data(wbytes),
      .pop_n(tx_pop_n), .head(tx_head), .count(tx_count)
   );

   spi_bufreg_mstr #(.NB(4)) i_mstr (
      .clk(clk), .rst_n(rst_n), .load(mst_load), .load_n(nb),
      .load_data(wbytes), .ready(mst_ready),
      .valid(mst_valid), .byte_out(mst_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_master <= 1'b0;
         ctrl_txie   <= 1'b0;
         ctrl_rxie   <= 1'b0;
         cfg_width   <= 2'd1;
         rx_trig     <= '0;
         tx_trig     <= '0;
      end else if (wr_en) begin
         case (bus_addr)
            ADR_CTRL: begin
               ctrl_master <= bus_wdata[3];
               ctrl_txie   <= bus_wdata[5];
               ctrl_rxie   <= bus_wdata[7];
            end
            ADR_WID:  cfg_width <= bus_wdata[6:5];
            ADR_BUFC: begin
               rx_trig <= bus_wdata[2:0];
               tx_trig <= bus_wdata[5:4];
            end
            default: ;
         endcase
      end
   end

   assign rx_lvl = int'(rx_count) >= int'(rx_trig);
   assign tx_low = int'(tx_count) <= int'(tx_trig);
   assign tx_end = (tx_count == '0);
   assign irq    = {1'b0, ctrl_txie && tx_low, ctrl_rxie && rx_lvl};

   always_comb begin
      cnt_word        = '0;
      cnt_word[5:0]   = 6'(rx_count);
      cnt_word[11:8]  = 4'(tx_count);
      case (nb)
         3'd4:    data_word = {rx_head[0], rx_head[1], rx_head[2], rx_head[3]};
         3'd2:    data_word = {16'h0000, rx_head[0], rx_head[1]};
         default: data_word = {24'h000000, rx_head[0]};
      endcase
      case (bus_addr)
         ADR_CTRL: rd_mux = {24'h0, ctrl_rxie, 1'b0, ctrl_txie, 1'b0, ctrl_master, 3'b000};
         ADR_STAT: rd_mux = {24'h0, rx_lvl, tx_end, tx_low, 5'b00000};
         ADR_WID:  rd_mux = {24'h0, 1'b0, cfg_width, 5'b00000};
         ADR_BUFC: rd_mux = {24'h0, 2'b00, tx_trig, 1'b0, rx_trig};
         ADR_CNT:  rd_mux = cnt_word;
         ADR_DATA: rd_mux = rd_ok ? data_word : 32'h0;
         default:  rd_mux = 32'h0;
      endcase
   end

   assign bus_rdata = rd_en ? rd_mux : 32'h0;

   // R2: a data read of the wrong size yields zero
   p_bad_width_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && hit_data && !width_ok |-> bus_rdata == 32'h0);

   // R4: a read that finds too few bytes yields zero
   p_short_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && hit_data && (int'(rx_count) < int'(nb)) |-> bus_rdata == 32'h0);

   // R7: a receive flush leaves the FIFO empty
   p_rx_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_flush |=> rx_count == '0);

   // R9: master role leaves the transmit FIFO alone
   p_master_tx_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_master && !tx_flush |=> $stable(tx_count));

endmodule

// File: tb/test_spi_bufreg.sv
`timescale 1ns/1ps
module test_spi_bufreg;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [1:0]  bus_size = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [2:0]  irq;
   logic        mst_valid, mst_ready = 1'b1;
   logic [7:0]  mst_byte, mst_rx_byte;
   logic        slv_valid = 1'b0;
   logic [7:0]  slv_byte = '0, slv_reply;

   int n_tests = 0;
   int n_fail  = 0;
   logic [7:0] exp_q [$];

   always #10 clk = ~clk;

   assign mst_rx_byte = ~mst_byte;  // peer returns the inverted byte

   spi_bufreg i_spi_bufreg (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq), .mst_valid(mst_valid),
      .mst_byte(mst_byte), .mst_ready(mst_ready), .mst_rx_byte(mst_rx_byte),
      .slv_valid(slv_valid), .slv_byte(slv_byte), .slv_reply(slv_reply)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic bwr(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic brd(input logic [7:0] a, input logic [1:0] s, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = s;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic sbyte(input logic [7:0] b, output logic [7:0] r);
      @(negedge clk);
      slv_valid = 1'b1; slv_byte = b;
      #1 r = slv_reply;
      @(negedge clk);
      slv_valid = 1'b0;
   endtask

   task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v;
      brd(a, 2'd2, v);
      chk(req, v, exp);
   endtask

   // monitor: each byte the peer takes is compared with the scoreboard queue
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (mst_valid && mst_ready) begin
            n_tests++;
            if (exp_q.size() == 0) begin
               n_fail++;
               $display("FAIL R9: unexpected master byte got %h expected none", mst_byte);
            end else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               if (mst_byte !== e) begin
                  n_fail++;
                  $display("FAIL R9: master byte got %h expected %h", mst_byte, e);
               end
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [7:0]  r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk_reg("R1 status", ADR_S, 32'hE0);
      chk_reg("R1 width", 8'h0B, 32'h20);
      chk_reg("R1 counts", 8'h22, 32'h0);
      chk("R1 irq", {29'h0, irq}, 32'h0);

      // R3 slave writes, R2 mismatched write
      bwr(8'h04, 2'd1, 32'h11);
      chk_reg("R3 tx count 1", 8'h22, 32'h0100);
      bwr(8'h0B, 2'd1, 32'h60);
      chk_reg("R2 width 32", 8'h0B, 32'h60);
      bwr(8'h04, 2'd3, 32'hA1B2C3D4);
      chk_reg("R3 tx count 5", 8'h22, 32'h0500);
      bwr(8'h04, 2'd1, 32'h55);
      chk_reg("R2 dropped write", 8'h22, 32'h0500);

      // R3/R10 slave replies in order
      sbyte(8'h01, r); chk("R3 reply0", {24'h0, r}, 32'h11);
      sbyte(8'h02, r); chk("R3 reply1", {24'h0, r}, 32'hA1);
      sbyte(8'h03, r); chk("R3 reply2", {24'h0, r}, 32'hB2);
      sbyte(8'h04, r); chk("R3 reply3", {24'h0, r}, 32'hC3);
      sbyte(8'h05, r); chk("R3 reply4", {24'h0, r}, 32'hD4);
      sbyte(8'h06, r); chk("R10 empty reply", {24'h0, r}, 32'h00);
      chk_reg("R10 rx count 6", 8'h22, 32'h0006);

      // R2 mismatched read, R4 packing
      brd(8'h04, 2'd2, v); chk("R2 bad read", v, 32'h0);
      chk_reg("R2 no pop", 8'h22, 32'h0006);
      brd(8'h04, 2'd3, v); chk("R4 word read", v, 32'h01020304);
      bwr(8'h0B, 2'd1, 32'h40);
      brd(8'h04, 2'd2, v); chk("R4 half read", v, 32'h0506);
      brd(8'h04, 2'd2, v); chk("R4 empty read", v, 32'h0);
      chk_reg("R4 empty count", 8'h22, 32'h0);
      sbyte(8'h77, r);
      brd(8'h04, 2'd2, v); chk("R4 short read", v, 32'h0);
      chk_reg("R4 short count", 8'h22, 32'h0001);
      bwr(8'h0B, 2'd1, 32'h20);
      brd(8'h04, 2'd1, v); chk("R4 byte read", v, 32'h77);

      // R5/R6 thresholds and interrupts
      bwr(8'h20, 2'd1, 32'h03);
      chk_reg("R5 status below trig", 8'h03, 32'h60);
      bwr(8'h00, 2'd1, 32'hA0);
      chk("R6 irq tx only", {29'h0, irq}, 32'h2);
      sbyte(8'h31, r); sbyte(8'h32, r); sbyte(8'h33, r);
      chk_reg("R5 rx at trig", 8'h03, 32'hE0);
      chk("R6 irq both", {29'h0, irq}, 32'h3);
      bwr(8'h0B, 2'd1, 32'h40);
      bwr(8'h04, 2'd2, 32'h1234);
      chk_reg("R5 tx above trig", 8'h03, 32'h80);
      chk("R6 irq rx only", {29'h0, irq}, 32'h1);
      bwr(8'h20, 2'd1, 32'h23);
      chk_reg("R5 tx trig 2", 8'h03, 32'hA0);
      chk_reg("R8 counts", 8'h22, 32'h0203);

      // R7 flush
      bwr(8'h20, 2'd1, 32'hC3);
      chk_reg("R7 counts", 8'h22, 32'h0);
      chk_reg("R7 status", 8'h03, 32'h60);
      chk("R7 irq", {29'h0, irq}, 32'h2);
      chk_reg("R7 bufc read", 8'h20, 32'h03);

      // R11 receive overflow, R12 collision
      bwr(8'h0B, 2'd1, 32'h20);
      for (int i = 0; i < 34; i++) sbyte(8'(i), r);
      chk_reg("R11 rx full", 8'h22, 32'h0020);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h04; bus_size = 2'd1;
      slv_valid = 1'b1; slv_byte = 8'hEE;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0; slv_valid = 1'b0;
      chk("R12 collision data", v, 32'h00);
      chk_reg("R12 collision count", 8'h22, 32'h0020);
      for (int i = 1; i < 32; i++) begin
         brd(8'h04, 2'd1, v);
         chk("R11 rx order", v, 32'(i));
      end
      brd(8'h04, 2'd1, v); chk("R12 pushed byte last", v, 32'hEE);

      // R11 transmit overflow
      bwr(8'h0B, 2'd1, 32'h60);
      bwr(8'h04, 2'd3, 32'h00010203);
      bwr(8'h04, 2'd3, 32'h04050607);
      bwr(8'h04, 2'd3, 32'h08090A0B);
      chk_reg("R11 tx full", 8'h22, 32'h0800);
      for (int i = 0; i < 8; i++) begin
         sbyte(8'h00, r);
         chk("R11 tx order", {24'h0, r}, 32'(i));
      end
      sbyte(8'h00, r); chk("R11 tx excess dropped", {24'h0, r}, 32'h0);
      bwr(8'h20, 2'd1, 32'hC3);

      // R9 master role
      bwr(8'h00, 2'd1, 32'h08);
      exp_q.push_back(8'hCA); exp_q.push_back(8'hFE);
      exp_q.push_back(8'hF0); exp_q.push_back(8'h0D);
      bwr(8'h04, 2'd3, 32'hCAFEF00D);
      repeat (8) @(negedge clk);
      chk_reg("R9 rx filled, tx untouched", 8'h22, 32'h0004);
      brd(8'h04, 2'd3, v); chk("R9 returned bytes", v, 32'h35010FF2);
      mst_ready = 1'b0;
      exp_q.push_back(8'h01); exp_q.push_back(8'h02);
      exp_q.push_back(8'h03); exp_q.push_back(8'h04);
      bwr(8'h04, 2'd3, 32'h01020304);
      bwr(8'h04, 2'd3, 32'h99999999);
      repeat (2) @(negedge clk);
      chk("R9 hold", {23'h0, mst_valid, mst_byte}, 32'h101);
      mst_ready = 1'b1;
      repeat (8) @(negedge clk);
      chk_reg("R9 busy write dropped", 8'h22, 32'h0004);
      brd(8'h04, 2'd3, v); chk("R9 returned bytes 2", v, 32'hFEFDFCFB);
      chk("R9 scoreboard drained", 32'(exp_q.size()), 32'h0);

      // R10 strobe ignored in master role
      sbyte(8'h42, r); chk("R10 master reply", {24'h0, r}, 32'h0);
      chk_reg("R10 master ignores strobe", 8'h22, 32'h0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   localparam logic [7:0] ADR_S = 8'h03;

endmodule